// File: doc/BRIEF.md
# DMA Channel Transfer-Mode Engine

This block keeps the working state of one channel of a DMA controller: the current memory address and the remaining transfer count. When the bus sequencer reports that a transfer has finished, the engine steps the address up or down by one and counts the transfer off. It also decides whether the channel keeps the bus for another transfer or gives it back. That decision depends on the selected transfer mode, the request line and the end conditions.

Software first presents a base address and a base count and pulses a load strobe. That copies both values into the working registers and unmasks the channel. From then on, a request line starts a service period. The count rolling from zero to all ones marks terminal count, and together with an external end-of-process input it ends the work. An auto-reload option makes the channel reload itself from the base values and stay armed; without it the channel masks itself until it is loaded again.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset `in_service`, `tc`, `eop`, `cur_addr` and `cur_count` are 0 and `masked` is 1.
- R2: One cycle after `prog_load`, `cur_addr` equals `base_addr`, `cur_count` equals `base_count`, `masked` is 0 and `in_service` is 0; `prog_load` takes priority over every other input.
- R3: Each `xfer_done` pulse during service decrements `cur_count` by one and moves `cur_addr` by one, up when `addr_down` is 0 and down when it is 1, wrapping modulo 2^AW.
- R4: A transfer completed while `cur_count` is 0 leaves `cur_count` at all ones and raises `tc` for one cycle on the next cycle.
- R5: With `xfer_mode` 2'b01 or 2'b11 (single), service ends after each transfer.
- R6: With `xfer_mode` 2'b10 (block), service continues whatever `dreq` does, until terminal count or `eop_in`.
- R7: With `xfer_mode` 2'b00 (demand), service ends in the cycle after `dreq` is seen low; address and count are kept, and a later request resumes from them.
- R8: Terminal count or `eop_in` during service raises `eop` for one cycle and ends the service in every mode.
- R9: With `auto_reload` 1, an end of process reloads `cur_addr` and `cur_count` from the base inputs and leaves the channel unmasked.
- R10: With `auto_reload` 0, terminal count sets `masked`, and `dreq` then starts no service until the next `prog_load`.
- R11: Outside service, `xfer_done` has no effect on `cur_addr` or `cur_count`.
- R12: When the channel is idle and unmasked, `dreq` high makes `in_service` 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_load | input | 1 | Copy base values into the working registers and unmask |
| xfer_mode | input | 2 | 00 demand, 01 single, 10 block, 11 single |
| addr_down | input | 1 | 1 steps the address down, 0 steps it up |
| auto_reload | input | 1 | Reload from the base values at end of process |
| base_addr | input | AW | Base address |
| base_count | input | CW | Base count |
| dreq | input | 1 | Channel request |
| eop_in | input | 1 | External end-of-process request |
| xfer_done | input | 1 | One-cycle pulse from the sequencer when a transfer finishes |
| cur_addr | output | AW | Current address |
| cur_count | output | CW | Current remaining count |
| in_service | output | 1 | 1 keeps the bus, 0 releases it |
| tc | output | 1 | Terminal-count pulse |
| eop | output | 1 | End-of-process pulse |
| masked | output | 1 | Channel is masked |

## Verification
The bench steps a channel through terminal count one transfer at a time. A design that fired terminal count at zero rather than on the rollover would finish one transfer early and leave the count at 0 rather than FFFFh. Decrementing runs are placed across address 0000h, and incrementing runs across FFFFh. A carry leaking out of the field would show as a wrong address there. The bench drops `dreq` in block mode, which must be ignored, and in demand mode, where it must release the bus with the state kept and the next request resuming from it. A design that confused the two would release early or hang on the bus. After terminal count without auto-reload, the bench drives a request to prove the mask blocks it. In auto-reload mode it checks that the base values come back and the channel stays armed.

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_load,
  input  logic [1:0]    xfer_mode,
  input  logic          addr_down,
  input  logic          auto_reload,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] base_count,
  input  logic          dreq,
  input  logic          eop_in,
  input  logic          xfer_done,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count,
  output logic          in_service,
  output logic          tc,
  output logic          eop,
  output logic          masked
);

  localparam logic [1:0] MODE_DEMAND = 2'b00;
  localparam logic [1:0] MODE_BLOCK  = 2'b10;

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          svc_q, tc_q, eop_q, mask_q;

  wire is_demand  = (xfer_mode == MODE_DEMAND);
  wire is_block   = (xfer_mode == MODE_BLOCK);
  wire step       = svc_q & xfer_done;
  wire roll       = step & (cnt_q == '0);
  wire proc_end   = roll | (svc_q & eop_in);
  wire single_end = step & ~is_block & ~is_demand;
  wire dreq_drop  = svc_q & is_demand & ~dreq;
  wire svc_end    = proc_end | single_end | dreq_drop;
  wire start      = ~svc_q & ~mask_q & dreq;

  wire [AW-1:0] addr_next = addr_down ? addr_q - AW'(1) : addr_q + AW'(1);
  wire [CW-1:0] cnt_next  = cnt_q - CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      svc_q  <= 1'b0;
      tc_q   <= 1'b0;
      eop_q  <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      tc_q  <= 1'b0;
      eop_q <= 1'b0;
      if (prog_load) begin
        addr_q <= base_addr;
        cnt_q  <= base_count;
        mask_q <= 1'b0;
        svc_q  <= 1'b0;
      end else begin
        if (step) begin
          addr_q <= addr_next;
          cnt_q  <= cnt_next;
        end
        if (proc_end && auto_reload) begin
          addr_q <= base_addr;
          cnt_q  <= base_count;
        end
        if (roll && !auto_reload) mask_q <= 1'b1;
        tc_q  <= roll;
        eop_q <= proc_end;
        if (svc_q && svc_end) svc_q <= 1'b0;
        else if (start)       svc_q <= 1'b1;
      end
    end
  end

  assign cur_addr   = addr_q;
  assign cur_count  = cnt_q;
  assign in_service = svc_q;
  assign tc         = tc_q;
  assign eop        = eop_q;
  assign masked     = mask_q;

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    step && !proc_end && !prog_load |=> cur_count == CW'($past(cur_count) - CW'(1)));

  a_r5_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    in_service && xfer_done && xfer_mode[0] && !prog_load |=> !in_service);

  a_r6_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_service && is_block && !xfer_done && !eop_in && !prog_load |=> in_service);

  a_r8_eop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> !in_service);

  a_r10_tc_masks: assert property (@(posedge clk) disable iff (!rst_n)
    roll && !auto_reload && !prog_load |=> masked && tc);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_service && !prog_load |=> $stable(cur_addr) && $stable(cur_count));

endmodule

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_load = 1'b0;
  logic [1:0]  xfer_mode = 2'b01;
  logic        addr_down = 1'b0;
  logic        auto_reload = 1'b0;
  logic [15:0] base_addr = '0;
  logic [15:0] base_count = '0;
  logic        dreq = 1'b0;
  logic        eop_in = 1'b0;
  logic        xfer_done = 1'b0;
  logic [15:0] cur_addr, cur_count;
  logic        in_service, tc, eop, masked;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dma_xfer_engine #(.AW(16), .CW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_load(prog_load), .xfer_mode(xfer_mode),
    .addr_down(addr_down), .auto_reload(auto_reload), .base_addr(base_addr),
    .base_count(base_count), .dreq(dreq), .eop_in(eop_in), .xfer_done(xfer_done),
    .cur_addr(cur_addr), .cur_count(cur_count), .in_service(in_service),
    .tc(tc), .eop(eop), .masked(masked));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] c);
    base_addr = a; base_count = c; prog_load = 1'b1;
    step();
    prog_load = 1'b0;
    chk("R2 addr", cur_addr, a);
    chk("R2 count", cur_count, c);
    chk("R2 mask", masked, 0);
    chk("R2 idle", in_service, 0);
  endtask

  task automatic xfer();
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] ea, ec;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 service", in_service, 0);
    chk("R1 mask", masked, 1);
    chk("R1 tc", tc, 0);
    chk("R1 eop", eop, 0);
    chk("R1 addr", cur_addr, 0);
    chk("R1 count", cur_count, 0);
    dreq = 1'b1; step();
    chk("R10 masked after reset blocks dreq", in_service, 0);
    dreq = 1'b0;

    // single mode, incrementing, no reload: walk to terminal count
    xfer_mode = 2'b01; addr_down = 1'b0; auto_reload = 1'b0;
    load(16'h1000, 16'd3);
    ea = 16'h1000; ec = 16'd3;
    dreq = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R12 start", in_service, 1);
      xfer();
      ea = ea + 16'd1; ec = ec - 16'd1;
      chk("R3 addr", cur_addr, ea);
      chk("R3 count", cur_count, ec);
      chk("R5 single release", in_service, 0);
      chk("R4 tc", tc, (i == 3));
      chk("R8 eop", eop, (i == 3));
    end
    chk("R4 rollover count", cur_count, 16'hFFFF);
    chk("R10 mask set", masked, 1);
    step(); step();
    chk("R10 dreq ignored", in_service, 0);
    dreq = 1'b0;
    xfer();
    chk("R11 addr", cur_addr, 16'h1004);
    chk("R11 count", cur_count, 16'hFFFF);

    // mode code 11 also behaves as single
    xfer_mode = 2'b11;
    load(16'h0200, 16'd5);
    dreq = 1'b1; step();
    xfer();
    chk("R5 code 11 release", in_service, 0);
    dreq = 1'b0; step();

    // block mode, decrementing across zero, auto reload
    xfer_mode = 2'b10; addr_down = 1'b1; auto_reload = 1'b1;
    load(16'h0001, 16'd4);
    ea = 16'h0001; ec = 16'd4;
    dreq = 1'b1; step();
    chk("R12 block start", in_service, 1);
    dreq = 1'b0;
    step();
    chk("R6 dreq drop ignored", in_service, 1);
    for (int i = 0; i < 5; i++) begin
      xfer();
      ea = ea - 16'd1; ec = ec - 16'd1;
      if (i < 4) begin
        chk("R3 dec addr", cur_addr, ea);
        chk("R3 dec count", cur_count, ec);
        chk("R6 block continues", in_service, 1);
      end else begin
        chk("R4 tc block", tc, 1);
        chk("R8 eop block", eop, 1);
        chk("R8 block release", in_service, 0);
        chk("R9 reload addr", cur_addr, 16'h0001);
        chk("R9 reload count", cur_count, 16'd4);
        chk("R9 unmasked", masked, 0);
      end
    end
    dreq = 1'b1; step();
    chk("R9 rearmed", in_service, 1);
    eop_in = 1'b1; step(); eop_in = 1'b0; dreq = 1'b0;
    chk("R8 ext eop block", eop, 1);
    chk("R8 ext eop release", in_service, 0);
    chk("R9 reload after ext eop", cur_addr, 16'h0001);

    // demand mode, incrementing across FFFF, no reload
    xfer_mode = 2'b00; addr_down = 1'b0; auto_reload = 1'b0;
    load(16'hFFFE, 16'd10);
    dreq = 1'b1; step();
    xfer(); xfer();
    chk("R7 demand continues", in_service, 1);
    chk("R3 wrap addr", cur_addr, 16'h0000);
    dreq = 1'b0; step();
    chk("R7 release on drop", in_service, 0);
    chk("R7 addr kept", cur_addr, 16'h0000);
    chk("R7 count kept", cur_count, 16'd8);
    dreq = 1'b1; step();
    chk("R7 resume", in_service, 1);
    xfer();
    chk("R7 resumed addr", cur_addr, 16'h0001);
    chk("R7 resumed count", cur_count, 16'd7);
    eop_in = 1'b1; step(); eop_in = 1'b0;
    chk("R8 ext eop demand", eop, 1);
    chk("R8 no tc on ext eop", tc, 0);
    chk("R8 demand release", in_service, 0);
    chk("R10 ext eop no mask", masked, 0);
    chk("R8 addr kept no reload", cur_addr, 16'h0001);
    dreq = 1'b0;
    step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule